// File: doc/BRIEF.md
# Self-Reloading Programmable Clock Divider

The block divides its clock by a programmable ratio N between 2 and 64. A 6-bit down-counter steps towards zero. A registered terminal-count flag goes low for one clock when the count reaches zero. That flag is fed back as the load command, so the next clock edge copies the preset input into the counter and the flag returns high. Counting then starts again. The load consumes one clock, so a preset of P gives a period of P + 1 clocks, and the user programs N - 1 to divide by N.

Both polarities of the divided signal are available. The active-low output pulses low for one clock per period. The active-high output is its complement. The control is a two-state machine. In `ST_COUNT` the counter decrements. The transition `count_to_reload` is taken when the count is about to step from one to zero. `ST_RELOAD` is the terminal-count cycle, in which the counter loads the preset. The transition `reload_to_count` is always taken after one clock. Reset is asynchronous and active high. It clears the counter and puts the machine in `ST_COUNT`. The first pulse after reset therefore comes only once the cleared count has wrapped round and returned to zero.

Top module: `clk_div_reload`

## Requirements
- R1: While `rst` is high, `div_n` is 1 and `div_p` is 0. This holds at once when `rst` rises, without waiting for a clock edge.
- R2: After `rst` falls, the first low pulse on `div_n` appears after the 64th rising clock edge, whatever value `preset` holds.
- R3: After the first pulse, with a constant `preset` P in the range 1 to 63, `div_n` is low for exactly one clock in every P + 1 clocks.
- R4: `preset` is sampled only on the clock edge that ends a low pulse. A change to `preset` at any other time has no effect on the period in progress, and it sets the length of the following period.
- R5: `div_p` is always the complement of `div_n`.
- R6: The extreme ratios work. A `preset` of 1 (binary 000001) gives a period of 2 clocks, and a `preset` of 63 (binary 111111) gives a period of 64 clocks.
- R7: Asserting `rst` in the middle of a period cancels that period. After `rst` is released, timing restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| preset | input | 6 | Reload value, which equals the divide ratio minus one |
| div_n | output | 1 | Divided output, low for one clock per period |
| div_p | output | 1 | Complement of `div_n` |

## Verification
The assertions assume that `preset` is never zero in the cycle where it is reloaded. A zero preset would give a 65-clock period, which lies outside the supported range. The stimulus draws every preset with `$urandom` from the range 1 to 63, and it also uses directed values at both ends of that range. It changes `preset` only on falling clock edges. Most changes are made during a pulse, so that they take effect at once. One deliberate change is made in the middle of a period to show that the preset is not sampled outside the reload edge.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

    // Two control states: counting, or terminal count with reload
    typedef enum logic {
        ST_COUNT  = 1'b0,
        ST_RELOAD = 1'b1
    } div_state_t;

endpackage

// File: rtl/div_counter.sv
module div_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic [W-1:0] cnt,
    output logic         at_one
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= preset;
        else           cnt <= cnt - ONE;
    end

    // The next decrement lands on zero
    assign at_one = (cnt == ONE);

    // R4: a reload copies the preset that was present at the reload edge
    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(preset)));

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import clk_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic at_one,
    output logic load,
    output logic div_n,
    output logic div_p
);
    div_state_t state, state_nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_COUNT;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COUNT:  if (at_one) state_nxt = ST_RELOAD; // count_to_reload
            ST_RELOAD: state_nxt = ST_COUNT;              // reload_to_count
            default:   state_nxt = ST_COUNT;
        endcase
    end

    always_comb begin
        load  = (state == ST_RELOAD);
        div_n = (state != ST_RELOAD);
        div_p = (state == ST_RELOAD);
    end

    // R3: terminal count lasts exactly one clock
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELOAD) |=> (state == ST_COUNT));

endmodule

// File: rtl/clk_div_reload.sv
module clk_div_reload #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] preset,
    output logic         div_n,
    output logic         div_p
);
    logic [W-1:0] cnt;
    logic         at_one;
    logic         load;

    div_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .preset (preset),
        .cnt    (cnt),
        .at_one (at_one)
    );

    div_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .at_one (at_one),
        .load   (load),
        .div_n  (div_n),
        .div_p  (div_p)
    );

    // R3: the output pulse coincides with a zero count
    a_r3_zero_at_pulse: assert property (@(posedge clk) disable iff (rst)
        !div_n |-> (cnt == '0));

    // R3: the pulse is followed by a high output
    a_r3_pulse_ends: assert property (@(posedge clk) disable iff (rst)
        !div_n |=> div_n);

    // Input assumption: a zero preset is never reloaded
    a_r6_preset_nonzero: assert property (@(posedge clk) disable iff (rst)
        !div_n |-> (preset != '0));

    // R5: the two outputs are complementary
    always_comb begin
        if (rst == 1'b0) begin
            a_r5_complement: assert (div_p == ~div_n);
        end
    end

endmodule

// File: tb/test_clk_div_reload.sv
module test_clk_div_reload;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] preset = 6'd5;
    logic       div_n, div_p;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    clk_div_reload i_clk_div_reload (
        .clk(clk), .rst(rst), .preset(preset), .div_n(div_n), .div_p(div_p)
    );

    always #10 clk = ~clk;

    function automatic int exp_period(input logic [5:0] p);
        return int'(p) + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until div_n is seen low; returns the count
    task automatic to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (div_p != ~div_n) check("R5", int'(div_p), int'(~div_n));
        end while (div_n && n < 200);
    endtask

    // At a pulse: set the preset, then measure the next period
    task automatic run_period(input logic [5:0] p, input string req);
        int n;
        preset = p;
        to_pulse(n);
        check(req, n, exp_period(p));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [5:0] a, b;
        void'($urandom(32'd1234));
        #5;
        check("R1", int'(div_n), 1);
        check("R1", int'(div_p), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        to_pulse(n);
        check("R2", n, 64);
        check("R3", int'(div_n), 0);
        @(negedge clk);
        n = 1;
        check("R3", int'(div_n), 1);
        while (div_n && n < 200) begin @(negedge clk); n++; end
        check("R3", n, exp_period(6'd5));

        run_period(6'd1, "R6");
        run_period(6'd1, "R6");
        run_period(6'd63, "R6");
        run_period(6'd36, "R3");
        run_period(6'd36, "R3");

        for (int i = 0; i < 40; i++) begin
            a = 6'(($urandom % 63) + 1);
            run_period(a, "R3");
        end

        // R4: change the preset in the middle of a period
        a = 6'd9; b = 6'd20;
        preset = a;
        @(negedge clk);
        preset = b;
        n = 1;
        while (div_n && n < 200) begin @(negedge clk); n++; end
        check("R4", n, exp_period(a));
        to_pulse(n);
        check("R4", n, exp_period(b));

        // R7: reset in the middle of a period
        preset = 6'd30;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        #2;
        check("R7", int'(div_n), 1);
        check("R1", int'(div_p), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        to_pulse(n);
        check("R7", n, 64);
        to_pulse(n);
        check("R7", n, exp_period(6'd30));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule